// File: doc/BRIEF.md
# GPIO Interrupt Routing Controller

This block takes a wide bank of general-purpose input pins and steers a chosen few of them onto eight interrupt request lines that feed an upstream interrupt controller. Every output channel owns an 8-bit source number naming the pin it watches, so software can attach any pin to any channel at run time. A source value of all ones, or any number beyond the implemented pin count, leaves the channel detached and its output quiet.

Each channel senses either a level or an edge. A per-channel inverter sits ahead of the sensing logic, so a low-active pin or a falling edge reaches the parent as a high level or a single-cycle rising pulse. Only one edge direction is ever sensed by one channel. The pins are brought into the clock domain by a two-stage synchronizer before selection.

Software programs the block through a plain 32-bit register bus with byte strobes. There are four word registers: the mode and inversion controls, two source-select words and a filter word that is kept as storage only.

Top module: `gpio_irq_router`

## Requirements
- R1: There are eight outputs `irq_out[7:0]`. Channel n takes its source number from bits [8*(n%4)+7 : 8*(n%4)] of the word at offset 0x04 for n = 0..3 and of the word at offset 0x08 for n = 4..7.
- R2: A source number of 0xFF, or one not below the pin count `N_GPIO` (133 by default), detaches the channel: its output stays 0 whatever the pins, mode or inversion.
- R3: In the word at offset 0x00, bit n set puts channel n in edge mode (clear means level mode) and bit 16+n inverts channel n's input; all other bits of that word read 0.
- R4: In level mode the output equals the selected pin XOR the inversion bit, and a pin change driven between two clock edges first shows on the output after the third following rising edge.
- R5: In edge mode the output is a pulse exactly one clock long for each 0-to-1 change of the inverted selected pin, appearing with the same three-edge latency as R4; the opposite change produces no pulse.
- R6: A change of a channel's source number, inversion or mode does not by itself produce an edge-mode pulse, even when it flips the value the channel sees.
- R7: After reset the word at 0x00 reads 0, the words at 0x04 and 0x08 read 0xFFFFFFFF, the word at 0x0C reads 0 and all outputs are 0.
- R8: A write updates only the bytes whose strobe bit `bus_be[k]` is set (bit k covers data bits 8k+7..8k).
- R9: The word at 0x0C is 32 bits of read/write storage and has no effect on any output.
- R10: Offsets 0x10 and above read 0 and writes to them change no register. `bus_rdata` shows the word at `bus_addr` in the same cycle; bits [1:0] of the address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write enable, taken at the rising edge |
| bus_addr | input | ADDR_W (6) | Byte address of the register access |
| bus_be | input | 4 | Byte strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gpio_in | input | N_GPIO (133) | Asynchronous pin inputs |
| irq_out | output | 8 | Interrupt requests to the parent controller |

## Verification
The hardest case to reach is a reconfiguration that changes what an edge-mode channel sees at the very cycle the new setting lands, such as moving the select from a low pin to a high one or flipping the inverter while the pin sits low; a correct design must stay silent there. The bench parks a channel in edge mode on a quiet pin, holds a neighbouring pin high, then retargets or inverts through the bus and counts pulses across the following cycles. Random rounds also load select values of 0xFF and above the pin count alongside random filter words, and compare every output with the value the requirements predict.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

    localparam int NCH   = 8;
    localparam int SEL_W = 8;
    localparam int DW    = 32;
    localparam int NBE   = DW / 8;

    localparam logic [SEL_W-1:0] SEL_NONE = '1;

    // Bits of the control word that hold state: mode lane at the bottom,
    // inversion lane starting at bit 16.
    localparam logic [DW-1:0] LANE_MASK = (DW'(1) << NCH) - DW'(1);
    localparam logic [DW-1:0] CTRL_MASK = LANE_MASK | (LANE_MASK << 16);

    typedef enum logic [1:0] {
        W_CTRL  = 2'd0,
        W_SELLO = 2'd1,
        W_SELHI = 2'd2,
        W_FILT  = 2'd3
    } word_e;

    typedef struct packed {
        logic [SEL_W-1:0] src;
        logic             edge_md;
        logic             invert;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{src: SEL_NONE, edge_md: 1'b0, invert: 1'b0};

    function automatic logic [DW-1:0] be_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [NBE-1:0] be);
        logic [DW-1:0] r;
        for (int b = 0; b < NBE; b++) begin
            r[8*b +: 8] = be[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;

endmodule

// File: rtl/gpirq_regs.sv
module gpirq_regs
    import gpirq_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [NBE-1:0]        bus_be,
    input  logic [DW-1:0]         bus_wdata,
    output logic [DW-1:0]         bus_rdata,
    output chan_cfg_t [NCH-1:0]   cfg_o
);
    localparam int SEL_BITS = NCH * SEL_W;

    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] sello_q;
    logic [DW-1:0] selhi_q;
    logic [DW-1:0] filt_q;

    logic  mapped;
    word_e widx;

    assign mapped = (bus_addr[ADDR_W-1:4] == '0);
    assign widx   = word_e'(bus_addr[3:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            sello_q <= '1;
            selhi_q <= '1;
            filt_q  <= '0;
        end else if (bus_wr && mapped) begin
            unique case (widx)
                W_CTRL:  ctrl_q  <= be_merge(ctrl_q,  bus_wdata, bus_be) & CTRL_MASK;
                W_SELLO: sello_q <= be_merge(sello_q, bus_wdata, bus_be);
                W_SELHI: selhi_q <= be_merge(selhi_q, bus_wdata, bus_be);
                W_FILT:  filt_q  <= be_merge(filt_q,  bus_wdata, bus_be);
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (mapped) begin
            unique case (widx)
                W_CTRL:  bus_rdata = ctrl_q;
                W_SELLO: bus_rdata = sello_q;
                W_SELHI: bus_rdata = selhi_q;
                W_FILT:  bus_rdata = filt_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    logic [SEL_BITS-1:0] sel_all;
    assign sel_all = {selhi_q, sello_q};

    for (genvar c = 0; c < NCH; c++) begin : g_cfg
        assign cfg_o[c].src     = sel_all[SEL_W*c +: SEL_W];
        assign cfg_o[c].edge_md = ctrl_q[c];
        assign cfg_o[c].invert  = ctrl_q[16 + c];
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (bus_rdata == '0)); // R10

    AST_UNMAPPED_NOWRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !mapped) |=> ($stable(ctrl_q) && $stable(sello_q) &&
                                 $stable(selhi_q) && $stable(filt_q))); // R10

    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctrl_q == '0 && sello_q == '1 && selhi_q == '1 && filt_q == '0)); // R7

    AST_NO_STROBE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_be == '0) |=> ($stable(ctrl_q) && $stable(sello_q) &&
                                      $stable(selhi_q) && $stable(filt_q))); // R8

endmodule

// File: rtl/gpirq_channel.sv
module gpirq_channel
    import gpirq_pkg::*;
#(
    parameter int N_GPIO = 133
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_GPIO-1:0] gpio_s,
    input  chan_cfg_t         cfg,
    output logic              irq_o
);
    localparam int PAD_W = 1 << SEL_W;

    logic [PAD_W-1:0] pins_pad;
    logic             sel_ok;
    logic             raw;
    logic             lvl;
    logic             prev_q;
    logic             irq_q;
    logic             cfg_chg;
    chan_cfg_t        cfg_q;

    assign pins_pad = PAD_W'(gpio_s);
    assign sel_ok   = (cfg.src != SEL_NONE) && (int'(cfg.src) < N_GPIO);
    assign raw      = pins_pad[cfg.src];
    assign lvl      = sel_ok & (raw ^ cfg.invert);
    assign cfg_chg  = (cfg != cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            prev_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            cfg_q  <= cfg;
            prev_q <= lvl;
            if (cfg.edge_md) begin
                irq_q <= lvl & ~prev_q & ~cfg_chg;
            end else begin
                irq_q <= lvl;
            end
        end
    end

    assign irq_o = irq_q;

    AST_UNASSIGNED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sel_ok |=> !irq_o); // R2

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (cfg.edge_md && !cfg_chg && irq_o) |=> !irq_o); // R5

    AST_CFG_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cfg.edge_md && cfg_chg) |=> !irq_o); // R6

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpirq_pkg::*;
#(
    parameter int N_GPIO = 133,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_GPIO-1:0] gpio_in,
    output logic [7:0]        irq_out
);
    chan_cfg_t [NCH-1:0] cfg;
    logic [N_GPIO-1:0]   gpio_s;

    gpirq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg)
    );

    gpirq_sync #(.W(N_GPIO)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (gpio_in),
        .q   (gpio_s)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        gpirq_channel #(.N_GPIO(N_GPIO)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .gpio_s (gpio_s),
            .cfg    (cfg[c]),
            .irq_o  (irq_out[c])
        );
    end

    AST_RESET_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq_out == '0)); // R7

endmodule

// File: tb/gpio_irq_router_test.sv
module gpio_irq_router_test;
    localparam int NG = 133;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NG-1:0] gpio = '0;
    logic [7:0]  irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] m_sel [8];
    logic [7:0] m_edge = '0;
    logic [7:0] m_inv = '0;

    always #2 clk = ~clk;

    gpio_irq_router uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gpio_in(gpio), .irq_out(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, req, bus_rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_sel(input int ch, input logic [7:0] v);
        logic [5:0] a;
        a = (ch < 4) ? 6'h04 : 6'h08;
        m_sel[ch] = v;
        wr(a, 32'(v) << (8 * (ch % 4)), 4'b0001 << (ch % 4));
    endtask

    task automatic set_ctrl();
        wr(6'h00, {8'h00, m_inv, 8'h00, m_edge}, 4'hF);
    endtask

    function automatic logic exp_lvl(input int ch);
        if (m_sel[ch] != 8'hFF && int'(m_sel[ch]) < NG)
            return gpio[m_sel[ch]] ^ m_inv[ch];
        return 1'b0;
    endfunction

    task automatic count_pulses(input int ch, input int n, output int cnt, output int first);
        cnt = 0; first = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq[ch]) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
    endtask

    function automatic logic [7:0] rand_sel();
        int k;
        k = $urandom % 4;
        if (k == 0) return 8'hFF;
        if (k == 1) return 8'(133 + ($urandom % 122));
        return 8'($urandom % NG);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt, first;
        void'($urandom(32'h5EED_1234));
        for (int c = 0; c < 8; c++) m_sel[c] = 8'hFF;

        wait_cyc(3);
        rst = 1'b0;

        // Reset state
        rd_chk(6'h00, 32'h0, "R7 ctrl reset");
        rd_chk(6'h04, 32'hFFFF_FFFF, "R7 sel lo reset");
        rd_chk(6'h08, 32'hFFFF_FFFF, "R7 sel hi reset");
        rd_chk(6'h0C, 32'h0, "R7 filter reset");
        check(irq == 8'h00, "R7 outputs reset", 32'(irq), 32'h0);

        // Byte strobes
        wr(6'h04, 32'h0000_1200, 4'b0010);
        rd_chk(6'h04, 32'hFFFF_12FF, "R8 byte strobe sel");
        wr(6'h04, 32'hFFFF_FFFF, 4'hF);
        wr(6'h0C, 32'hA5A5_A5A5, 4'b0101);
        rd_chk(6'h0C, 32'h00A5_00A5, "R8/R9 filter strobes");

        // Reserved control bits
        wr(6'h00, 32'hFFFF_FFFF, 4'hF);
        rd_chk(6'h00, 32'h00FF_00FF, "R3 reserved bits");
        wr(6'h00, 32'h0, 4'hF);

        // Unmapped space
        wr(6'h10, 32'h1234_5678, 4'hF);
        wr(6'h3C, 32'h1234_5678, 4'hF);
        rd_chk(6'h10, 32'h0, "R10 unmapped read 0x10");
        rd_chk(6'h3C, 32'h0, "R10 unmapped read 0x3C");
        rd_chk(6'h00, 32'h0, "R10 ctrl after unmapped write");
        rd_chk(6'h0C, 32'h00A5_00A5, "R10 filter after unmapped write");
        rd_chk(6'h05, 32'hFFFF_FFFF, "R10 low address bits ignored");

        // Level latency and routing
        set_sel(3, 8'd10);
        rd_chk(6'h04, 32'h0AFF_FFFF, "R1 channel 3 field position");
        wait_cyc(4);
        gpio[10] = 1'b1;
        wait_cyc(2);
        check(irq == 8'h00, "R4 no output before third edge", 32'(irq), 32'h0);
        wait_cyc(1);
        check(irq == 8'h08, "R4 level after third edge / R1 routing", 32'(irq), 32'h08);
        gpio[10] = 1'b0;
        wait_cyc(4);
        check(irq == 8'h00, "R4 level falls", 32'(irq), 32'h0);

        // Detached channels
        set_sel(3, 8'd200);
        m_inv[3] = 1'b1; set_ctrl();
        wait_cyc(4);
        check(irq[3] == 1'b0, "R2 out-of-range select inverted", 32'(irq[3]), 32'h0);
        set_sel(3, 8'hFF);
        wait_cyc(4);
        check(irq == 8'h00, "R2 unassigned select inverted", 32'(irq), 32'h0);
        m_inv[3] = 1'b0; set_ctrl();
        m_sel[3] = 8'hFF;

        // Edge mode on channel 5 (second word)
        set_sel(5, 8'd20);
        rd_chk(6'h08, 32'hFFFF_14FF, "R1 channel 5 field position");
        m_edge[5] = 1'b1; set_ctrl();
        wait_cyc(5);
        gpio[20] = 1'b1;
        count_pulses(5, 6, cnt, first);
        check(cnt == 1, "R5 rising pulse count", 32'(cnt), 32'd1);
        check(first == 2, "R5 pulse latency", 32'(first), 32'd2);
        gpio[20] = 1'b0;
        count_pulses(5, 6, cnt, first);
        check(cnt == 0, "R5 falling edge ignored", 32'(cnt), 32'd0);

        // Inversion flip while pin low: seen value rises but no pulse
        m_inv[5] = 1'b1; set_ctrl();
        count_pulses(5, 6, cnt, first);
        check(cnt == 0, "R6 inversion change no pulse", 32'(cnt), 32'd0);
        gpio[20] = 1'b1;
        count_pulses(5, 6, cnt, first);
        check(cnt == 0, "R5 inverted rising ignored", 32'(cnt), 32'd0);
        gpio[20] = 1'b0;
        count_pulses(5, 6, cnt, first);
        check(cnt == 1, "R5 inverted falling pulse", 32'(cnt), 32'd1);

        // Source change from low pin to high pin
        m_inv[5] = 1'b0; set_ctrl();
        gpio[21] = 1'b1;
        wait_cyc(5);
        set_sel(5, 8'd21);
        count_pulses(5, 6, cnt, first);
        check(cnt == 0, "R6 select change no pulse", 32'(cnt), 32'd0);
        gpio[21] = 1'b0;
        m_edge = '0; set_ctrl();

        // Random level rounds
        for (int it = 0; it < 30; it++) begin
            logic [31:0] lo, hi, fv;
            for (int c = 0; c < 8; c++) m_sel[c] = rand_sel();
            m_inv = 8'($urandom);
            m_edge = '0;
            lo = {m_sel[3], m_sel[2], m_sel[1], m_sel[0]};
            hi = {m_sel[7], m_sel[6], m_sel[5], m_sel[4]};
            fv = $urandom;
            wr(6'h04, lo, 4'hF);
            wr(6'h08, hi, 4'hF);
            wr(6'h0C, fv, 4'hF);
            set_ctrl();
            for (int b = 0; b < NG; b++) gpio[b] = 1'($urandom);
            wait_cyc(4);
            begin
                logic [7:0] e;
                for (int c = 0; c < 8; c++) e[c] = exp_lvl(c);
                check(irq == e, "R4/R2/R9 random level outputs", 32'(irq), 32'(e));
            end
            rd_chk(6'h08, hi, "R1 random select readback");
        end

        // Random edge rounds
        for (int it = 0; it < 10; it++) begin
            int ch;
            logic [7:0] s;
            ch = $urandom % 8;
            s = 8'($urandom % NG);
            set_sel(ch, s);
            m_inv[ch] = 1'($urandom);
            m_edge[ch] = 1'b1;
            set_ctrl();
            gpio[s] = m_inv[ch];
            wait_cyc(5);
            gpio[s] = ~m_inv[ch];
            count_pulses(ch, 6, cnt, first);
            check(cnt == 1 && first == 2, "R5 random edge pulse", 32'(cnt), 32'd1);
            m_edge[ch] = 1'b0;
            set_ctrl();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule